// File: doc/BRIEF.md
# Dual-Image Flash Configuration Loader

This block brings up an FPGA by copying a configuration bitstream out of an asynchronous parallel flash into the target device over its byte-wide passive parallel configuration pins. The flash holds two 1 MB images. By default the loader tries the user image first. When that image cannot bring the target to a configured state, the loader restarts the load from the safe image without outside help. A safe-start input skips the user image and loads only the safe image.

A load can be started in four ways: release of power-on reset, a reconfigure button pulse, an active-low reconfiguration request from the target, or a safe-configure button pulse. Four status LEDs report progress. One LED marks the user image and one marks the safe image; each lights during its attempt and stays lit after that image succeeds. A third LED blinks while bytes are moving. A fourth LED lights when both images have failed. When the target is reconfigured over JTAG, the loader aborts any transfer and all four LEDs go dark.

Top module: `cfg_loader`

## Requirements
- R1: At reset all LEDs are off, `tgt_config_n` is high and `tgt_dclk` is low. When reset is released, the block starts a user attempt, holding `tgt_config_n` low for exactly NCFG_LOW_CLKS clocks, with `led_user` lit.
- R2: An attempt waits for `tgt_status_n` high, then reads consecutive flash addresses. A user attempt starts at 0x600000 and a safe attempt at 0x700000. On each byte's `tgt_dclk` high cycle, `tgt_data` equals the flash byte at the current `flash_addr`.
- R3: For each image byte, `flash_addr` is stable for at least ACCESS_CLKS+1 clocks up to and including the `tgt_dclk` high cycle. `tgt_dclk` is never high for two clocks in a row.
- R4: Once `tgt_conf_done` is high, exactly INIT_CLKS further `tgt_dclk` pulses are issued. After that, no further `tgt_dclk` pulses are issued. The image's LED stays lit, and `led_loading` and `led_error` are off.
- R5: A user image fails if `tgt_status_n` goes low during transfer, or if all REGION_BYTES bytes are sent without `tgt_conf_done`. A failed user image is followed by a safe attempt from 0x700000, with `led_safe` lit and `led_user` off. An image that raises `tgt_conf_done` on exactly its last region byte succeeds.
- R6: A rising edge on `btn_safe` starts a single safe attempt and never reads the user image.
- R7: When the safe image fails, `led_error` lights, the other three LEDs are off, and `tgt_dclk` stays idle.
- R8: `led_loading` blinks only while bytes are being transferred, with high phases of BLINK_DIV clocks. It is off in every other state.
- R9: A rising edge on `jtag_cfg` turns all four LEDs off on the next clock, stops all `tgt_dclk` activity, and leaves `tgt_config_n` high. This takes priority over any start in the same clock.
- R10: A rising edge on `btn_reconfig` or a falling edge on `reconf_req_n` starts a new user-first attempt at any time. If it coincides with a `btn_safe` edge, the safe start wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset; releasing it starts a load |
| btn_reconfig | input | 1 | Debounced reconfigure button, active high |
| btn_safe | input | 1 | Debounced safe-configure button, active high |
| reconf_req_n | input | 1 | Active-low reload request from the target |
| jtag_cfg | input | 1 | High when the target has been configured over JTAG |
| flash_addr | output | ADDR_W | Flash byte address |
| flash_data | input | 8 | Flash read data |
| tgt_config_n | output | 1 | Target configuration reset, active low |
| tgt_status_n | input | 1 | Target status, low on reset or error |
| tgt_conf_done | input | 1 | Target configuration complete |
| tgt_dclk | output | 1 | Configuration data clock |
| tgt_data | output | 8 | Configuration data byte |
| led_user | output | 1 | User image active or loaded |
| led_safe | output | 1 | Safe image active or loaded |
| led_loading | output | 1 | Blinks during transfer |
| led_error | output | 1 | Neither image configured the target |

## Verification
A state register stuck in the transfer loop would show up at the ports as DCLK pulses continuing after configuration completes, or as the wrong LED being lit. Either symptom appears within a few clocks. A wrong image flag or a wrong offset shows up on the very first byte as an address that does not start at the expected base or does not step by one. A faulty fallback decision shows up in the count of nCONFIG pulses, one region length after the failing byte. A prescaler fault shows up as a loading-LED high phase of the wrong length within one blink period.

// File: rtl/cfgl_pkg.sv
package cfgl_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CFG_LOW,
        ST_WAIT_ST,
        ST_FETCH,
        ST_CLK,
        ST_GAP,
        ST_FAIL,
        ST_INIT,
        ST_DONE,
        ST_ERROR
    } ld_state_e;
endpackage

// File: rtl/cfgl_trigger.sv
module cfgl_trigger (
    input  logic clk,
    input  logic rst_n,
    input  logic btn_reconfig,
    input  logic btn_safe,
    input  logic reconf_req_n,
    input  logic jtag_cfg,
    output logic start_user,
    output logic start_safe,
    output logic jtag_hit
);
    typedef struct packed {
        logic por;
        logic btn_rc;
        logic btn_sf;
        logic req_n;
        logic jtag;
    } trig_t;

    trig_t q, d;

    always_comb begin
        d        = q;
        d.por    = 1'b0;
        d.btn_rc = btn_reconfig;
        d.btn_sf = btn_safe;
        d.req_n  = reconf_req_n;
        d.jtag   = jtag_cfg;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{por: 1'b1, btn_rc: 1'b0, btn_sf: 1'b0, req_n: 1'b1, jtag: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign start_safe = btn_safe & ~q.btn_sf;
    assign start_user = q.por | (btn_reconfig & ~q.btn_rc) | (~reconf_req_n & q.req_n);
    assign jtag_hit   = jtag_cfg & ~q.jtag;
endmodule

// File: rtl/cfgl_blink.sv
module cfgl_blink #(
    parameter int BLINK_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic phase
);
    localparam int BW = $clog2(BLINK_DIV + 1);

    logic [BW-1:0] cnt_d, cnt_q;
    logic          ph_d, ph_q;

    always_comb begin
        cnt_d = cnt_q + 1'b1;
        ph_d  = ph_q;
        if (cnt_q == BW'(BLINK_DIV - 1)) begin
            cnt_d = '0;
            ph_d  = ~ph_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            ph_q  <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            ph_q  <= ph_d;
        end
    end

    assign phase = ph_q;
endmodule

// File: rtl/cfg_loader.sv
module cfg_loader #(
    parameter int              ADDR_W        = 23,
    parameter logic [ADDR_W-1:0] USER_BASE   = 23'h600000,
    parameter logic [ADDR_W-1:0] SAFE_BASE   = 23'h700000,
    parameter int              REGION_BYTES  = 1048576,
    parameter int              ACCESS_CLKS   = 2,
    parameter int              NCFG_LOW_CLKS = 8,
    parameter int              INIT_CLKS     = 8,
    parameter int              BLINK_DIV     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              btn_reconfig,
    input  logic              btn_safe,
    input  logic              reconf_req_n,
    input  logic              jtag_cfg,
    output logic [ADDR_W-1:0] flash_addr,
    input  logic [7:0]        flash_data,
    output logic              tgt_config_n,
    input  logic              tgt_status_n,
    input  logic              tgt_conf_done,
    output logic              tgt_dclk,
    output logic [7:0]        tgt_data,
    output logic              led_user,
    output logic              led_safe,
    output logic              led_loading,
    output logic              led_error
);
    import cfgl_pkg::*;

    localparam int OFF_W   = $clog2(REGION_BYTES);
    localparam int CNT_A   = (ACCESS_CLKS > NCFG_LOW_CLKS) ? ACCESS_CLKS : NCFG_LOW_CLKS;
    localparam int CNT_MAX = (CNT_A > 2 * INIT_CLKS) ? CNT_A : 2 * INIT_CLKS;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    typedef struct packed {
        ld_state_e        state;
        logic             img_safe;
        logic             safe_only;
        logic [CNT_W-1:0] cnt;
        logic [OFF_W-1:0] off;
        logic [7:0]       data;
    } ld_t;

    ld_t q, d;

    logic start_user, start_safe, jtag_hit, blink;

    cfgl_trigger i_trig (
        .clk          (clk),
        .rst_n        (rst_n),
        .btn_reconfig (btn_reconfig),
        .btn_safe     (btn_safe),
        .reconf_req_n (reconf_req_n),
        .jtag_cfg     (jtag_cfg),
        .start_user   (start_user),
        .start_safe   (start_safe),
        .jtag_hit     (jtag_hit)
    );

    cfgl_blink #(.BLINK_DIV(BLINK_DIV)) i_blink (
        .clk   (clk),
        .rst_n (rst_n),
        .phase (blink)
    );

    always_comb begin
        d = q;
        unique case (q.state)
            ST_IDLE: ;
            ST_CFG_LOW: begin
                if (q.cnt == CNT_W'(NCFG_LOW_CLKS - 1)) begin
                    d.state = ST_WAIT_ST;
                    d.cnt   = '0;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            ST_WAIT_ST: begin
                if (tgt_status_n) begin
                    d.state = ST_FETCH;
                    d.cnt   = '0;
                    d.off   = '0;
                end
            end
            ST_FETCH: begin
                if (q.cnt == CNT_W'(ACCESS_CLKS - 1)) begin
                    d.state = ST_CLK;
                    d.cnt   = '0;
                    d.data  = flash_data;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            ST_CLK: d.state = ST_GAP;
            ST_GAP: begin
                if (tgt_conf_done) begin
                    d.state = ST_INIT;
                    d.cnt   = '0;
                end else if (!tgt_status_n || q.off == OFF_W'(REGION_BYTES - 1)) begin
                    d.state = ST_FAIL;
                end else begin
                    d.state = ST_FETCH;
                    d.off   = q.off + 1'b1;
                end
            end
            ST_FAIL: begin
                if (!q.img_safe && !q.safe_only) begin
                    d.state    = ST_CFG_LOW;
                    d.img_safe = 1'b1;
                    d.cnt      = '0;
                end else begin
                    d.state = ST_ERROR;
                end
            end
            ST_INIT: begin
                if (q.cnt == CNT_W'(2 * INIT_CLKS - 1)) begin
                    d.state = ST_DONE;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            ST_DONE, ST_ERROR: ;
            default: d.state = ST_IDLE;
        endcase

        if (jtag_hit) begin
            d.state = ST_IDLE;
        end else if (start_safe) begin
            d.state     = ST_CFG_LOW;
            d.img_safe  = 1'b1;
            d.safe_only = 1'b1;
            d.cnt       = '0;
        end else if (start_user) begin
            d.state     = ST_CFG_LOW;
            d.img_safe  = 1'b0;
            d.safe_only = 1'b0;
            d.cnt       = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{state: ST_IDLE, img_safe: 1'b0, safe_only: 1'b0,
                   cnt: '0, off: '0, data: '0};
        end else begin
            q <= d;
        end
    end

    logic active, moving;
    assign active = (q.state != ST_IDLE) && (q.state != ST_ERROR);
    assign moving = (q.state == ST_FETCH) || (q.state == ST_CLK) || (q.state == ST_GAP);

    assign flash_addr   = (q.img_safe ? SAFE_BASE : USER_BASE) + ADDR_W'(q.off);
    assign tgt_config_n = (q.state != ST_CFG_LOW);
    assign tgt_dclk     = (q.state == ST_CLK) || ((q.state == ST_INIT) && !q.cnt[0]);
    assign tgt_data     = q.data;
    assign led_user     = active && !q.img_safe;
    assign led_safe     = active && q.img_safe;
    assign led_loading  = moving && blink;
    assign led_error    = (q.state == ST_ERROR);
endmodule

// File: rtl/cfgl_loader_chk.sv
module cfgl_loader_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        jtag_cfg,
    input logic [22:0] flash_addr,
    input logic        tgt_config_n,
    input logic        tgt_dclk,
    input logic        led_user,
    input logic        led_safe,
    input logic        led_loading,
    input logic        led_error
);
    p_dclk_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_dclk |=> !tgt_dclk);

    p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_dclk |-> $stable(flash_addr));

    p_no_dclk_in_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !tgt_config_n |-> !tgt_dclk && !led_loading);

    p_one_image_led_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(led_user && led_safe));

    p_error_alone_r7: assert property (@(posedge clk) disable iff (!rst_n)
        led_error |-> !led_user && !led_safe && !led_loading && !tgt_dclk);

    p_jtag_dark_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(jtag_cfg) |=> !led_user && !led_safe && !led_loading && !led_error);
endmodule

bind cfg_loader cfgl_loader_chk i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .jtag_cfg     (jtag_cfg),
    .flash_addr   (flash_addr[22:0]),
    .tgt_config_n (tgt_config_n),
    .tgt_dclk     (tgt_dclk),
    .led_user     (led_user),
    .led_safe     (led_safe),
    .led_loading  (led_loading),
    .led_error    (led_error)
);

// File: tb/test_cfg_loader.sv
module test_cfg_loader;
    localparam int RB   = 32;
    localparam int ACC  = 2;
    localparam int NLOW = 8;
    localparam int NINI = 4;
    localparam int BDIV = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic btn_reconfig = 1'b0, btn_safe = 1'b0, reconf_req_n = 1'b1, jtag_cfg = 1'b0;
    logic [22:0] flash_addr;
    logic [7:0]  flash_data, tgt_data;
    logic tgt_config_n, tgt_dclk;
    logic tgt_status_n = 1'b0, tgt_conf_done = 1'b0;
    logic led_user, led_safe, led_loading, led_error;

    always #4 clk = ~clk;

    int checks = 0, fails = 0;
    logic [7:0] salt = 8'h00;

    function automatic logic [7:0] fbyte(input logic [22:0] a, input logic [7:0] s);
        return (a[7:0] * 8'd29) ^ a[15:8] ^ {a[20], 3'b000, a[3:0]} ^ s;
    endfunction

    assign flash_data = fbyte(flash_addr, salt);

    cfg_loader #(.REGION_BYTES(RB), .ACCESS_CLKS(ACC), .NCFG_LOW_CLKS(NLOW),
                 .INIT_CLKS(NINI), .BLINK_DIV(BDIV)) i_cfg_loader (
        .clk(clk), .rst_n(rst_n), .btn_reconfig(btn_reconfig), .btn_safe(btn_safe),
        .reconf_req_n(reconf_req_n), .jtag_cfg(jtag_cfg), .flash_addr(flash_addr),
        .flash_data(flash_data), .tgt_config_n(tgt_config_n), .tgt_status_n(tgt_status_n),
        .tgt_conf_done(tgt_conf_done), .tgt_dclk(tgt_dclk), .tgt_data(tgt_data),
        .led_user(led_user), .led_safe(led_safe), .led_loading(led_loading),
        .led_error(led_error));

    // target model and monitor
    int need_user = 10, need_safe = 12, fault_user = 0, fault_safe = 0;
    int attempts = 0, bytes = 0, prev_bytes = 0, init_pulses = 0, total_pulses = 0;
    int lowrun = 0, last_low = 0, stab = 0, run = 0, maxrun = 0;
    int err_r2 = 0, err_r3 = 0;
    logic [22:0] first_addr = '0, addr_prev = '0;
    logic cfg_prev = 1'b1, dclk_prev = 1'b0;

    always @(negedge clk) begin
        int need, fat;
        if (flash_addr == addr_prev) stab++; else stab = 1;
        addr_prev = flash_addr;
        if (led_loading) begin
            run++;
            if (run > maxrun) maxrun = run;
        end else run = 0;
        if (!tgt_config_n) begin
            if (cfg_prev) begin
                attempts++; prev_bytes = bytes; bytes = 0; init_pulses = 0; lowrun = 0;
            end
            lowrun++;
            tgt_conf_done = 1'b0;
            tgt_status_n  = 1'b0;
        end else begin
            if (!cfg_prev) last_low = lowrun;
            if (tgt_dclk) begin
                total_pulses++;
                if (dclk_prev) err_r3++;
                if (!tgt_conf_done) begin
                    if (bytes == 0) first_addr = flash_addr;
                    if (flash_addr != first_addr + 23'(bytes)) err_r2++;
                    if (tgt_data != fbyte(flash_addr, salt)) err_r2++;
                    if (stab < ACC + 1) err_r3++;
                    bytes++;
                    need = first_addr[20] ? need_safe : need_user;
                    if (bytes == need) tgt_conf_done = 1'b1;
                end else init_pulses++;
            end
            fat = first_addr[20] ? fault_safe : fault_user;
            tgt_status_n = !(fat != 0 && bytes >= fat);
        end
        cfg_prev  = tgt_config_n;
        dclk_prev = tgt_dclk;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        case (which)
            0: btn_reconfig = 1'b1;
            1: reconf_req_n = 1'b0;
            default: btn_safe = 1'b1;
        endcase
        @(negedge clk);
        btn_reconfig = 1'b0; reconf_req_n = 1'b1; btn_safe = 1'b0;
    endtask

    // expected LEDs {user, safe, error} after a start completes
    function automatic logic [2:0] exp_leds(input bit safe_start, input int nu, input int ns,
                                            input int fu, input int fs);
        bit u_ok = (nu <= RB) && (fu == 0 || fu >= nu);
        bit s_ok = (ns <= RB) && (fs == 0 || fs >= ns);
        if (!safe_start && u_ok) return 3'b100;
        if (s_ok) return 3'b010;
        return 3'b001;
    endfunction

    function automatic int exp_attempts(input bit safe_start, input int nu, input int fu);
        if (safe_start) return 1;
        return ((nu <= RB) && (fu == 0 || fu >= nu)) ? 1 : 2;
    endfunction

    task automatic check_leds(input string req, input logic [2:0] e);
        logic [2:0] a = {led_user, led_safe, led_error};
        check(a == e && !led_loading, req, int'({a, led_loading}), int'({e, 1'b0}));
    endtask

    task automatic check_quiet(input string req);
        int snap = total_pulses;
        cycles(100);
        check(total_pulses == snap, req, total_pulses, snap);
    endtask

    initial begin
        int a0;
        void'($urandom(32'd1234));
        salt = 8'($urandom);
        #1;
        check(tgt_config_n && !tgt_dclk && !led_user && !led_safe && !led_loading && !led_error,
              "R1 reset state", int'({tgt_config_n, tgt_dclk, led_user, led_safe}), 8);
        cycles(4);
        rst_n = 1'b1;
        cycles(3);
        check(led_user && !tgt_config_n, "R1 user attempt starts", int'(led_user), 1);
        cycles(600);
        check(last_low == NLOW, "R1 config low length", last_low, NLOW);
        check(attempts == 1, "R1 attempts", attempts, 1);
        check(first_addr == 23'h600000, "R2 user base", int'(first_addr), 'h600000);
        check(bytes == 10, "R2 byte count", bytes, 10);
        check(init_pulses == NINI, "R4 init pulses", init_pulses, NINI);
        check_leds("R4 user loaded LEDs", 3'b100);
        check(maxrun == BDIV, "R8 blink high phase", maxrun, BDIV);
        check_quiet("R4 reading stopped");

        // boundary: conf_done on the last region byte
        need_user = RB; a0 = attempts;
        pulse(0); cycles(600);
        check(attempts - a0 == 1, "R10 button restart", attempts - a0, 1);
        check(bytes == RB && init_pulses == NINI, "R5 last byte succeeds", bytes, RB);
        check_leds("R5 last byte LEDs", 3'b100);

        // user one byte too long: fallback via target request
        need_user = RB + 1; need_safe = 12; a0 = attempts;
        pulse(1); cycles(700);
        check(attempts - a0 == 2, "R10 request restart with fallback", attempts - a0, 2);
        check(prev_bytes == RB, "R5 user region exhausted", prev_bytes, RB);
        check(first_addr == 23'h700000, "R5 safe base", int'(first_addr), 'h700000);
        check_leds("R5 safe loaded LEDs", 3'b010);

        // status fault during user transfer
        need_user = 20; fault_user = 5; a0 = attempts;
        pulse(0); cycles(700);
        check(prev_bytes == 5, "R5 status fault stops user", prev_bytes, 5);
        check_leds("R5 fault fallback LEDs", 3'b010);
        fault_user = 0;

        // both images fail
        need_user = 40; need_safe = 40;
        pulse(0); cycles(700);
        check_leds("R7 error LEDs", 3'b001);
        check_quiet("R7 no DCLK after error");

        // safe-only start
        need_user = 10; need_safe = 9; a0 = attempts;
        pulse(2); cycles(600);
        check(attempts - a0 == 1, "R6 single attempt", attempts - a0, 1);
        check(first_addr == 23'h700000 && bytes == 9, "R6 safe only read", int'(first_addr), 'h700000);
        check_leds("R6 safe LEDs", 3'b010);

        need_safe = 50; a0 = attempts;
        pulse(2); cycles(600);
        check(attempts - a0 == 1, "R6 no user after safe failure", attempts - a0, 1);
        check_leds("R7 safe-only error", 3'b001);

        // JTAG abort mid-transfer
        need_user = 30;
        pulse(0); cycles(60);
        @(negedge clk) jtag_cfg = 1'b1;
        cycles(2);
        check({led_user, led_safe, led_loading, led_error} == 4'b0, "R9 LEDs dark",
              int'({led_user, led_safe, led_loading, led_error}), 0);
        check_quiet("R9 transfer halted");
        check(tgt_config_n, "R9 config_n high", int'(tgt_config_n), 1);
        @(negedge clk) jtag_cfg = 1'b0;

        // constrained random starts
        for (int i = 0; i < 10; i++) begin
            int kind = $urandom_range(0, 2);
            int nu = $urandom_range(1, RB + 8);
            int ns = $urandom_range(1, RB + 8);
            int fu = ($urandom_range(0, 3) == 0) ? $urandom_range(1, 10) : 0;
            need_user = nu; need_safe = ns; fault_user = fu; a0 = attempts;
            pulse(kind); cycles(700);
            check(attempts - a0 == exp_attempts(kind == 2, nu, fu), "R10 random attempts",
                  attempts - a0, exp_attempts(kind == 2, nu, fu));
            check_leds("R5 random outcome", exp_leds(kind == 2, nu, ns, fu, 0));
        end
        fault_user = 0;

        check(err_r2 == 0, "R2 address/data errors", err_r2, 0);
        check(err_r3 == 0, "R3 timing errors", err_r3, 0);
        check(maxrun == BDIV, "R8 blink phase overall", maxrun, BDIV);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule